// File: doc/BRIEF.md
# Clock Output Stop Gating

This block sits between a clock synthesizer and the output pads. It takes four free-running raw clocks (CPU, reference, SDRAM and PCI) and produces the fan-out copies of each. Some copies are gated and some run freely. A CPU stop request (`cpu_stop_n`, active low) halts the gated CPU copy, the reference-domain IOAPIC copy and the gated SDRAM copies. A PCI stop request (`pci_stop_n`, active low) halts the gated PCI copies. Each stop request is synchronised into the clock domain of the outputs it halts. The gate of each output only moves while its raw clock is low, so every pulse that appears is a whole pulse and no output glitches.

Every output also has its own enable bit. A cleared bit holds that output low, and this applies to the free-running copies too. The PCI stop request only works when `mode_strap` is 0. When the strap is 1, the request is ignored. When `hiz_mode` is 1, a separate output-enable per clock group tells the pads to float. The block never drives X or Z itself.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every clock output is low.
- R2: If `cpu_stop_n` is sampled low at rising edge k of its destination clock, the gated copies in that domain deliver the full pulse that starts at edge k+1. From edge k+2 on they stay low. The gated copies are `cpu_out[1]`, `ioapic_out` and `sdram_out[NUM_SDRAM-1:0]`.
- R3: If `cpu_stop_n` is sampled high at rising edge k, the gated copies resume with a full pulse starting at edge k+2.
- R4: `cpu_out[0]` and `sdram_out[NUM_SDRAM]` are free-running and ignore `cpu_stop_n`.
- R5: `pci_out[NUM_PCI:1]` are gated by `pci_stop_n` in the PCI clock domain, with the same k+1 and k+2 timing as R2 and R3. `pci_out[0]` is free-running and ignores `pci_stop_n`.
- R6: When `mode_strap` is 1, `pci_stop_n` has no effect and the PCI copies behave as if the request were high.
- R7: An enable bit is sampled at each falling edge of its clock. If the bit is 0, the output is held low for the following high phase. Bit i of each enable vector controls bit i of the matching output vector.
- R8: `cpu_oe`, `ioapic_oe`, `sdram_oe` and `pci_oe` are all 0 while `hiz_mode` is 1 and all 1 otherwise, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_clk | input | 1 | Raw CPU clock |
| ref_clk | input | 1 | Raw reference clock |
| sdram_clk | input | 1 | Raw SDRAM clock |
| pci_clk | input | 1 | Raw PCI clock |
| cpu_stop_n | input | 1 | CPU-side stop request, active low |
| pci_stop_n | input | 1 | PCI stop request, active low |
| mode_strap | input | 1 | 1 disables the PCI stop request |
| hiz_mode | input | 1 | 1 floats all outputs through the oe signals |
| cpu_en | input | 2 | Enables for cpu_out |
| ioapic_en | input | 1 | Enable for ioapic_out |
| sdram_en | input | NUM_SDRAM+1 | Enables for sdram_out |
| pci_en | input | NUM_PCI+1 | Enables for pci_out |
| cpu_out | output | 2 | CPU copies, bit 0 free-running |
| ioapic_out | output | 1 | Gated reference copy |
| sdram_out | output | NUM_SDRAM+1 | SDRAM copies, top bit free-running |
| pci_out | output | NUM_PCI+1 | PCI copies, bit 0 free-running |
| cpu_oe | output | 1 | Pad enable for cpu_out |
| ioapic_oe | output | 1 | Pad enable for ioapic_out |
| sdram_oe | output | 1 | Pad enable for sdram_out |
| pci_oe | output | 1 | Pad enable for pci_out |

## Verification
A stop request level that is sampled at rising edge k of a domain's clock first shows in the pulse that begins at edge k+2. An enable bit sampled at a falling edge shows in the next high phase. The pad enables follow `hiz_mode` with no delay. The reference model records the stop level at each rising edge in a queue per domain and forms the expected gate at each falling edge from the entry two edges back. It compares every output both 1 ns after each rising edge and 1 ns before the following falling edge, which confirms that the whole high phase is present or absent. Stimulus changes half-way between edges, so no sample races a change.

// File: rtl/clk_stop_gate.sv
`timescale 1ns/100ps
module clk_stop_gate #(
  parameter int NUM_SDRAM = 12,
  parameter int NUM_PCI   = 5
) (
  input  logic                 rst_n,
  input  logic                 cpu_clk,
  input  logic                 ref_clk,
  input  logic                 sdram_clk,
  input  logic                 pci_clk,
  input  logic                 cpu_stop_n,
  input  logic                 pci_stop_n,
  input  logic                 mode_strap,
  input  logic                 hiz_mode,
  input  logic [1:0]           cpu_en,
  input  logic                 ioapic_en,
  input  logic [NUM_SDRAM:0]   sdram_en,
  input  logic [NUM_PCI:0]     pci_en,
  output logic [1:0]           cpu_out,
  output logic                 ioapic_out,
  output logic [NUM_SDRAM:0]   sdram_out,
  output logic [NUM_PCI:0]     pci_out,
  output logic                 cpu_oe,
  output logic                 ioapic_oe,
  output logic                 sdram_oe,
  output logic                 pci_oe
);
  localparam int SW = NUM_SDRAM + 1;
  localparam int PW = NUM_PCI + 1;

  logic [1:0]    cpu_sy, ref_sy, sd_sy, pci_sy;
  logic [1:0]    cpu_g;
  logic          ref_g;
  logic [SW-1:0] sd_g;
  logic [PW-1:0] pci_g;
  logic          pci_req_n;

  assign pci_req_n = mode_strap | pci_stop_n;

  always_ff @(posedge cpu_clk or negedge rst_n)
    if (!rst_n) cpu_sy <= '0;
    else        cpu_sy <= {cpu_sy[0], cpu_stop_n};

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) ref_sy <= '0;
    else        ref_sy <= {ref_sy[0], cpu_stop_n};

  always_ff @(posedge sdram_clk or negedge rst_n)
    if (!rst_n) sd_sy <= '0;
    else        sd_sy <= {sd_sy[0], cpu_stop_n};

  always_ff @(posedge pci_clk or negedge rst_n)
    if (!rst_n) pci_sy <= '0;
    else        pci_sy <= {pci_sy[0], pci_req_n};

  always_ff @(negedge cpu_clk or negedge rst_n)
    if (!rst_n) cpu_g <= '0;
    else        cpu_g <= cpu_en & {cpu_sy[1], 1'b1};

  always_ff @(negedge ref_clk or negedge rst_n)
    if (!rst_n) ref_g <= 1'b0;
    else        ref_g <= ioapic_en & ref_sy[1];

  always_ff @(negedge sdram_clk or negedge rst_n)
    if (!rst_n) sd_g <= '0;
    else        sd_g <= sdram_en & {1'b1, {NUM_SDRAM{sd_sy[1]}}};

  always_ff @(negedge pci_clk or negedge rst_n)
    if (!rst_n) pci_g <= '0;
    else        pci_g <= pci_en & {{NUM_PCI{pci_sy[1]}}, 1'b1};

  assign cpu_out    = {2{cpu_clk}} & cpu_g;
  assign ioapic_out = ref_clk & ref_g;
  assign sdram_out  = {SW{sdram_clk}} & sd_g;
  assign pci_out    = {PW{pci_clk}} & pci_g;

  assign cpu_oe    = ~hiz_mode;
  assign ioapic_oe = ~hiz_mode;
  assign sdram_oe  = ~hiz_mode;
  assign pci_oe    = ~hiz_mode;
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/100ps
module clk_stop_gate_chk (
  input logic rst_n,
  input logic cpu_clk,
  input logic pci_clk,
  input logic cpu_stop_n,
  input logic pci_stop_n,
  input logic mode_strap,
  input logic cpu_en0,
  input logic cpu_en1,
  input logic pci_en1,
  input logic cpu0_out,
  input logic cpu1_out,
  input logic pci1_out
);
  AST_CPU_STOP_LOW: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    (!$past(cpu_stop_n, 2) && !$past(cpu_stop_n, 3)) |-> !cpu1_out); // R2

  AST_FREE_RUNS: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cpu_en0)) |-> cpu0_out); // R4

  AST_DISABLED_LOW: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    !$past(cpu_en1) |-> !cpu1_out); // R7

  AST_PCI_STOP_LOW: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (!$past(pci_stop_n, 2) && !$past(pci_stop_n, 3) &&
     !$past(mode_strap, 2) && !$past(mode_strap, 3)) |-> !pci1_out); // R5

  AST_STRAP_BYPASS: assert property (@(negedge pci_clk) disable iff (!rst_n)
    ($past(mode_strap, 2) && $past(mode_strap, 3) && $past(pci_en1) &&
     $past(rst_n, 3)) |-> pci1_out); // R6
endmodule

bind clk_stop_gate clk_stop_gate_chk u_chk (
  .rst_n(rst_n), .cpu_clk(cpu_clk), .pci_clk(pci_clk),
  .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .mode_strap(mode_strap),
  .cpu_en0(cpu_en[0]), .cpu_en1(cpu_en[1]), .pci_en1(pci_en[1]),
  .cpu0_out(cpu_out[0]), .cpu1_out(cpu_out[1]), .pci1_out(pci_out[1])
);

// File: tb/clk_stop_gate_bench.sv
`timescale 1ns/100ps
module clk_stop_gate_bench;
  localparam int NS = 12;
  localparam int NP = 5;

  logic rst_n = 0, cpu_clk = 0, ref_clk = 0, sdram_clk = 0, pci_clk = 0;
  logic cpu_stop_n = 1, pci_stop_n = 1, mode_strap = 0, hiz_mode = 0;
  logic [1:0]  cpu_en = '1;
  logic        ioapic_en = 1;
  logic [NS:0] sdram_en = '1;
  logic [NP:0] pci_en = '1;
  logic [1:0]  cpu_out;
  logic        ioapic_out;
  logic [NS:0] sdram_out;
  logic [NP:0] pci_out;
  logic cpu_oe, ioapic_oe, sdram_oe, pci_oe;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  clk_stop_gate u_clk_stop_gate (.*);

  always #4  cpu_clk   = ~cpu_clk;
  always #7  ref_clk   = ~ref_clk;
  always #5  sdram_clk = ~sdram_clk;
  always #15 pci_clk   = ~pci_clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // reference model: stop history queues per domain (index 1 = two rising edges back)
  bit cq[$], rq[$], sq[$], pq[$];
  logic [1:0]  m_cpu = '0;
  logic        m_ref = 0;
  logic [NS:0] m_sd = '0;
  logic [NP:0] m_pci = '0;

  function automatic bit back2(input bit q[$]);
    return (q.size() >= 2) ? q[1] : 1'b0;
  endfunction

  always @(posedge cpu_clk)   begin if (!rst_n) cq.delete(); else begin cq.push_front(cpu_stop_n); if (cq.size() > 4) void'(cq.pop_back()); end end
  always @(posedge ref_clk)   begin if (!rst_n) rq.delete(); else begin rq.push_front(cpu_stop_n); if (rq.size() > 4) void'(rq.pop_back()); end end
  always @(posedge sdram_clk) begin if (!rst_n) sq.delete(); else begin sq.push_front(cpu_stop_n); if (sq.size() > 4) void'(sq.pop_back()); end end
  always @(posedge pci_clk)   begin if (!rst_n) pq.delete(); else begin pq.push_front(mode_strap ? 1'b1 : pci_stop_n); if (pq.size() > 4) void'(pq.pop_back()); end end

  always @(negedge cpu_clk)   m_cpu = rst_n ? (cpu_en & {back2(cq), 1'b1}) : '0;
  always @(negedge ref_clk)   m_ref = rst_n ? (ioapic_en & back2(rq)) : 1'b0;
  always @(negedge sdram_clk) m_sd  = rst_n ? (sdram_en & {1'b1, {NS{back2(sq)}}}) : '0;
  always @(negedge pci_clk)   m_pci = rst_n ? (pci_en & {{NP{back2(pq)}}, 1'b1}) : '0;

  // compare early and late in each high phase
  always @(posedge cpu_clk) if (!done) begin
    for (int s = 0; s < 2; s++) begin
      #1;
      chk("R2 R3 R7 cpu gated copy", cpu_out[1], m_cpu[1]);
      chk("R4 R7 cpu free copy", cpu_out[0], m_cpu[0]);
      chk("R8 pad enables", {cpu_oe, ioapic_oe, sdram_oe, pci_oe}, {4{~hiz_mode}});
      #1;
    end
  end
  always @(posedge ref_clk) if (!done) begin
    #1 chk("R2 R3 R7 ioapic", ioapic_out, m_ref);
    #5 chk("R2 R3 R7 ioapic late", ioapic_out, m_ref);
  end
  always @(posedge sdram_clk) if (!done) begin
    #1 chk("R2 R3 R4 R7 sdram", sdram_out, m_sd);
    #3 chk("R2 R3 R4 R7 sdram late", sdram_out, m_sd);
  end
  always @(posedge pci_clk) if (!done) begin
    #1  chk("R5 R6 R7 pci", pci_out, m_pci);
    #13 chk("R5 R6 R7 pci late", pci_out, m_pci);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge cpu_clk);
    #2.5;
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    wait_cyc(6);
    // R1: all clock outputs low during reset
    @(posedge pci_clk); #1;
    chk("R1 reset outputs", {cpu_out, ioapic_out, sdram_out, pci_out}, '0);
    wait_cyc(1);
    rst_n = 1;
    wait_cyc(40);
    // R2 / R3: stop then restart all CPU-side gated copies
    cpu_stop_n = 0; wait_cyc(60);
    cpu_stop_n = 1; wait_cyc(60);
    // R5: PCI stop with strap 0
    pci_stop_n = 0; wait_cyc(80);
    pci_stop_n = 1; wait_cyc(40);
    // R6: strap 1 ignores a low request
    mode_strap = 1; wait_cyc(20);
    pci_stop_n = 0; wait_cyc(80);
    pci_stop_n = 1; wait_cyc(20);
    mode_strap = 0; wait_cyc(20);
    // R7: per-output enables, including free-running copies
    cpu_en = 2'b10; ioapic_en = 0; sdram_en = 13'h1A5A; pci_en = 6'b010110;
    wait_cyc(40);
    cpu_en = 2'b01; ioapic_en = 1; sdram_en = 13'h05A5; pci_en = 6'b101001;
    cpu_stop_n = 0; pci_stop_n = 0; wait_cyc(40);
    cpu_stop_n = 1; pci_stop_n = 1;
    cpu_en = '1; sdram_en = '1; pci_en = '1; wait_cyc(30);
    // R8: high-impedance mode
    hiz_mode = 1; wait_cyc(20);
    hiz_mode = 0; wait_cyc(10);
    // mixed stop traffic with varied hold times
    for (int i = 0; i < 60; i++) begin
      cpu_stop_n = $urandom_range(0, 1);
      pci_stop_n = $urandom_range(0, 1);
      wait_cyc($urandom_range(5, 14));
    end
    cpu_stop_n = 1; pci_stop_n = 1; wait_cyc(20);
    finish_run();
  end
endmodule